// File: doc/BRIEF.md
# Network Statistics Counter Bank

This block keeps four statistics counters for a network controller and makes them visible through a small register port. The first is a free-running time counter that advances on every clock and restarts when software writes to it. The second counts received packets that were thrown away because the receive FIFO overflowed. The last two count link disconnect events and false-carrier events.

Each counter follows its own clearing rule. A write of any value restarts the time counter. The dropped-packet counter is cleared only by a synchronous software reset strobe. The two link counters clear themselves when they are read, and they wrap around when they are full. Event inputs are single-cycle strobes from detection logic outside this block. The read port is registered: the word selected by `addr` while `rd_en` is high appears on `rd_data` after the next clock edge and stays there until the next read.

Top module: `net_stat_bank`

## Requirements
- R1: While the asynchronous reset is asserted, and right after it is released, all four counters are zero and `rd_data` is zero.
- R2: At word address 0 the time counter adds one on every clock edge at which there is no write to address 0. Two reads of address 0 that are N edges apart differ by N, modulo 2^TIME_W.
- R3: A write (`wr_en`) to address 0 sets the time counter to zero at that edge, whatever the write data would have been. A read at the following edge returns 0.
- R4: The time counter wraps from its all-ones value to zero.
- R5: At word address 1 the dropped-packet counter adds one for each `ovf_evt` strobe and wraps when full. A read returns it in the low DROP_W bits, and every bit above these reads as zero (with the default width, the top byte of the word).
- R6: The dropped-packet counter is cleared only by `soft_rst`. Reading it does not change it. A `soft_rst` in the same cycle as an `ovf_evt` leaves it at zero.
- R7: At word address 2 the disconnect counter adds one for each `disc_evt` strobe and wraps from all ones to zero.
- R8: At word address 3 the false-carrier counter adds one for each `fcar_evt` strobe and wraps from all ones to zero.
- R9: Reading address 2 or address 3 returns the counter's value as it was before the read edge and clears that counter at the same edge.
- R10: If an event strobe arrives in the same cycle as a clearing read of its counter, the read returns the old value and the counter holds 1 afterwards.
- R11: `rd_data` is loaded only at an edge where `rd_en` is high, and it holds its value otherwise. Addresses 4 and above read as zero. Writes to any address other than 0 change no counter.
- R12: `soft_rst` has no effect on the time counter or on the two link counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| soft_rst | input | 1 | Software reset strobe. It clears the dropped-packet counter. |
| ovf_evt | input | 1 | Receive FIFO overflow strobe: one packet dropped |
| disc_evt | input | 1 | Link disconnect event strobe |
| fcar_evt | input | 1 | False-carrier event strobe |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe. The data value is irrelevant. |
| addr | input | ADDR_W | Word address for the read or write |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench builds the block with a 12-bit time counter, an 8-bit dropped-packet counter and 4-bit link counters, with the read word kept at 32 bits. These narrow widths bring every wrap within reach in a few thousand cycles: the timer rolling over, the drop counter passing 255, and a link counter passing 15. The wide read word still shows that the bits above each counter read as zero. Directed tasks cover the coincident cases as well: an event arriving together with a clearing read, a software reset arriving together with an overflow, and writes and reads at unmapped or non-timer addresses.

// File: rtl/stat_pkg.sv
package stat_pkg;
  // Word addresses of the counter registers
  localparam int unsigned REG_TIME = 0;
  localparam int unsigned REG_DROP = 1;
  localparam int unsigned REG_DISC = 2;
  localparam int unsigned REG_FCAR = 3;
  localparam int unsigned REG_COUNT = 4;
endpackage

// File: rtl/stat_event_ctr.sv
module stat_event_ctr #(
  parameter int W           = 16,
  parameter bit KEEP_ON_CLR = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d, clr_val;
  logic         cnt_en;

  // The variant decides whether an event coincident with a clear survives
  generate
    if (KEEP_ON_CLR) begin : g_keep
      assign clr_val = W'(evt_i);
    end else begin : g_drop
      assign clr_val = '0;
    end
  endgenerate

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = clr_val;
    end else if (evt_i) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stat_free_timer.sv
module stat_free_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  output logic [W-1:0] time_o
);
  logic [W-1:0] time_q, time_d;

  always_comb begin
    if (restart_i) time_d = '0;
    else           time_d = time_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end

  assign time_o = time_q;
endmodule

// File: rtl/stat_reg_port.sv
module stat_reg_port
  import stat_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int TIME_W = 32,
  parameter int DROP_W = 24,
  parameter int LINK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TIME_W-1:0] time_cnt,
  input  logic [DROP_W-1:0] drop_cnt,
  input  logic [LINK_W-1:0] disc_cnt,
  input  logic [LINK_W-1:0] fcar_cnt,
  output logic              wr_hit_time,
  output logic              rd_hit_disc,
  output logic              rd_hit_fcar,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sel_word;
  logic [DATA_W-1:0] rd_q;
  logic              rd_load;

  assign wr_hit_time = wr_en && (addr == ADDR_W'(REG_TIME));
  assign rd_hit_disc = rd_en && (addr == ADDR_W'(REG_DISC));
  assign rd_hit_fcar = rd_en && (addr == ADDR_W'(REG_FCAR));

  // Counters are zero-extended into the read word
  always_comb begin
    sel_word = '0;
    if      (addr == ADDR_W'(REG_TIME)) sel_word = DATA_W'(time_cnt);
    else if (addr == ADDR_W'(REG_DROP)) sel_word = DATA_W'(drop_cnt);
    else if (addr == ADDR_W'(REG_DISC)) sel_word = DATA_W'(disc_cnt);
    else if (addr == ADDR_W'(REG_FCAR)) sel_word = DATA_W'(fcar_cnt);
  end

  assign rd_load = rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_load) rd_q <= sel_word;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/net_stat_bank.sv
module net_stat_bank #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int TIME_W = 32,
  parameter int DROP_W = 24,
  parameter int LINK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ovf_evt,
  input  logic              disc_evt,
  input  logic              fcar_evt,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [TIME_W-1:0] time_cnt;
  logic [DROP_W-1:0] drop_cnt;
  logic [LINK_W-1:0] disc_cnt;
  logic [LINK_W-1:0] fcar_cnt;
  logic              wr_hit_time;
  logic              rd_hit_disc;
  logic              rd_hit_fcar;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  stat_free_timer #(.W(TIME_W)) i_timer (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .restart_i (wr_hit_time),
    .time_o    (time_cnt)
  );

  stat_event_ctr #(.W(DROP_W), .KEEP_ON_CLR(1'b0)) i_drop_ctr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .evt_i (ovf_evt),
    .clr_i (soft_rst),
    .cnt_o (drop_cnt)
  );

  stat_event_ctr #(.W(LINK_W), .KEEP_ON_CLR(1'b1)) i_disc_ctr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .evt_i (disc_evt),
    .clr_i (rd_hit_disc),
    .cnt_o (disc_cnt)
  );

  stat_event_ctr #(.W(LINK_W), .KEEP_ON_CLR(1'b1)) i_fcar_ctr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .evt_i (fcar_evt),
    .clr_i (rd_hit_fcar),
    .cnt_o (fcar_cnt)
  );

  stat_reg_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TIME_W (TIME_W),
    .DROP_W (DROP_W),
    .LINK_W (LINK_W)
  ) i_port (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .addr        (addr),
    .time_cnt    (time_cnt),
    .drop_cnt    (drop_cnt),
    .disc_cnt    (disc_cnt),
    .fcar_cnt    (fcar_cnt),
    .wr_hit_time (wr_hit_time),
    .rd_hit_disc (rd_hit_disc),
    .rd_hit_fcar (rd_hit_fcar),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/net_stat_bank_chk.sv
module net_stat_bank_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int TIME_W = 32,
  parameter int DROP_W = 24,
  parameter int LINK_W = 16
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              soft_rst,
  input logic              disc_evt,
  input logic              fcar_evt,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [TIME_W-1:0] time_cnt,
  input logic [DROP_W-1:0] drop_cnt,
  input logic [LINK_W-1:0] disc_cnt,
  input logic [LINK_W-1:0] fcar_cnt
);
  logic wr_t, rd_disc, rd_fcar, rd_drop, rd_unmapped;
  assign wr_t        = wr_en && (addr == ADDR_W'(0));
  assign rd_drop     = rd_en && (addr == ADDR_W'(1));
  assign rd_disc     = rd_en && (addr == ADDR_W'(2));
  assign rd_fcar     = rd_en && (addr == ADDR_W'(3));
  assign rd_unmapped = rd_en && (addr >= ADDR_W'(4));

  assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !wr_t |=> time_cnt == TIME_W'($past(time_cnt) + 1'b1));

  assert_timer_restart_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_t |=> time_cnt == '0);

  assert_drop_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_drop |=> (rd_data >> DROP_W) == '0);

  assert_drop_soft_clear_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    soft_rst |=> drop_cnt == '0);

  assert_disc_wrap_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (disc_cnt == '1) && disc_evt && !rd_disc |=> disc_cnt == '0);

  assert_fcar_step_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    fcar_evt && !rd_fcar |=> fcar_cnt == LINK_W'($past(fcar_cnt) + 1'b1));

  assert_disc_read_old_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_disc |=> rd_data == DATA_W'($past(disc_cnt)));

  assert_fcar_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_fcar && !fcar_evt |=> fcar_cnt == '0);

  assert_disc_keep_event_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_disc && disc_evt |=> disc_cnt == LINK_W'(1));

  assert_hold_rdata_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rd_en |=> $stable(rd_data));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_unmapped |=> rd_data == '0);

  assert_soft_keeps_link_R12: assert property (@(posedge clk) disable iff (!rst_core_n)
    soft_rst && !disc_evt && !rd_disc |=> $stable(disc_cnt));
endmodule

bind net_stat_bank net_stat_bank_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .TIME_W (TIME_W),
  .DROP_W (DROP_W),
  .LINK_W (LINK_W)
) i_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .soft_rst   (soft_rst),
  .disc_evt   (disc_evt),
  .fcar_evt   (fcar_evt),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .addr       (addr),
  .rd_data    (rd_data),
  .time_cnt   (time_cnt),
  .drop_cnt   (drop_cnt),
  .disc_cnt   (disc_cnt),
  .fcar_cnt   (fcar_cnt)
);

// File: tb/test_net_stat_bank.sv
`timescale 1ns/1ps
module test_net_stat_bank;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int TIME_W = 12;
  localparam int DROP_W = 8;
  localparam int LINK_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              soft_rst, ovf_evt, disc_evt, fcar_evt, rd_en, wr_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  net_stat_bank #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .TIME_W (TIME_W),
    .DROP_W (DROP_W), .LINK_W (LINK_W)
  ) i_net_stat_bank (
    .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst), .ovf_evt (ovf_evt),
    .disc_evt (disc_evt), .fcar_evt (fcar_evt), .rd_en (rd_en),
    .wr_en (wr_en), .addr (addr), .rd_data (rd_data)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Read: strobe set at a falling edge, result sampled at the next falling edge
  task automatic do_read(input int a, output logic [DATA_W-1:0] v);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
    v = rd_data;
  endtask

  task automatic do_write(input int a);
    wr_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    wr_en = 1'b0; addr = '0;
  endtask

  task automatic pulse_evt(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      ovf_evt = (which == 0); disc_evt = (which == 1); fcar_evt = (which == 2);
      @(negedge clk);
      ovf_evt = 1'b0; disc_evt = 1'b0; fcar_evt = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] v;
    rst_n = 1'b0; soft_rst = 0; ovf_evt = 0; disc_evt = 0; fcar_evt = 0;
    rd_en = 0; wr_en = 0; addr = '0;
    repeat (4) @(negedge clk);
    check("R1 rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(1, v); check("R1 drop after reset", v, 0);
    do_read(2, v); check("R1 disc after reset", v, 0);
    do_read(3, v); check("R1 fcar after reset", v, 0);
  endtask

  task automatic t_timer();
    logic [DATA_W-1:0] v1, v2;
    do_read(0, v1);
    repeat (9) @(negedge clk);
    do_read(0, v2);
    check("R2 timer step", (v2 - v1) & 32'hFFF, 10);
    do_write(0);
    do_read(0, v1);
    check("R3 timer restart", v1, 0);
    do_write(0);
    repeat (4095) @(negedge clk);
    do_read(0, v1);
    do_read(0, v2);
    check("R4 timer at max", v1, 4095);
    check("R4 timer wrapped", v2, 0);
  endtask

  task automatic t_drop();
    logic [DATA_W-1:0] v;
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    pulse_evt(0, 300);
    do_read(1, v);
    check("R5 drop count mod width, upper zero", v, 300 % 256);
    do_read(1, v);
    check("R6 drop not cleared by read", v, 44);
    soft_rst = 1'b1; ovf_evt = 1'b1; @(negedge clk);
    soft_rst = 1'b0; ovf_evt = 1'b0;
    do_read(1, v);
    check("R6 soft reset wins over event", v, 0);
  endtask

  task automatic t_link();
    logic [DATA_W-1:0] v;
    pulse_evt(1, 15);
    do_read(2, v); check("R7 disc count", v, 15);
    do_read(2, v); check("R9 disc cleared by read", v, 0);
    pulse_evt(1, 17);
    do_read(2, v); check("R7 disc wrap", v, 1);
    pulse_evt(2, 5);
    do_read(3, v); check("R8 fcar count", v, 5);
    do_read(3, v); check("R9 fcar cleared by read", v, 0);
    pulse_evt(2, 16);
    do_read(3, v); check("R8 fcar wrap", v, 0);
  endtask

  task automatic t_coincide();
    logic [DATA_W-1:0] v;
    pulse_evt(1, 3);
    disc_evt = 1'b1;
    do_read(2, v);
    disc_evt = 1'b0;
    check("R10 read returns old", v, 3);
    do_read(2, v); check("R10 event kept", v, 1);
    pulse_evt(2, 2);
    fcar_evt = 1'b1;
    do_read(3, v);
    fcar_evt = 1'b0;
    check("R10 fcar read old", v, 2);
    do_read(3, v); check("R10 fcar event kept", v, 1);
  endtask

  task automatic t_port();
    logic [DATA_W-1:0] v;
    pulse_evt(1, 3);
    pulse_evt(0, 6);
    do_write(2); do_write(1); do_write(3);
    do_read(7, v); check("R11 unmapped reads zero", v, 0);
    repeat (3) @(negedge clk);
    check("R11 rd_data held", rd_data, 0);
    do_read(1, v); check("R11 write to drop ignored", v, 6);
    do_read(2, v); check("R11 write to disc ignored", v, 3);
  endtask

  task automatic t_soft();
    logic [DATA_W-1:0] v1, v2;
    pulse_evt(1, 2);
    do_read(0, v1);
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    do_read(0, v2);
    check("R12 timer unaffected by soft reset", (v2 - v1) & 32'hFFF, 2);
    do_read(2, v1);
    check("R12 disc unaffected by soft reset", v1, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_timer();
    t_drop();
    t_link();
    t_coincide();
    t_port();
    t_soft();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule